// File: doc/BRIEF.md
# Three-Level Grouped Interrupt Handler

This block gathers twenty-four interrupt source lines into three banks of eight: a low bank (sources 0 to 7), a mid bank (sources 8 to 15) and a high bank (sources 16 to 23). Each source line first passes through a two-flop synchronizer. A rising edge on the synchronized line sets a sticky flag, but only while that source's enable bit is 1. An enable bit therefore decides whether a flag can be set at all. It does not mask a flag that is already set.

Each bank with at least one flag set drives one of three CPU interrupt lines. The CPU services simultaneous lines in a fixed order: line 0 first, then line 1, then line 2. The high bank owns line 0, the mid bank line 1 and the low bank line 2.

Software works through a byte-wide bus. It can write and read the enable bytes, read the flag bytes, and clear flags by writing ones to them. A read-only code gives the index of the highest-numbered pending source. A read-only summary byte shows which banks have work pending.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset every enable bit is 0. The enable bytes sit at address 0x4 (low bank), 0x5 (mid bank) and 0x6 (high bank) and read back what was written. Bit n of bank g governs source 8*g+n.
- R2: When an enabled source line rises, its flag bit becomes 1. The flag bytes are at 0x0 (low), 0x1 (mid) and 0x2 (high), with bit n of bank g standing for source 8*g+n. The flag is visible after the third rising clock edge that follows the input change (two synchronizer stages, then the flag register).
- R3: A rising edge on a source whose enable bit is 0 leaves its flag at 0.
- R4: A source held high without a new rising edge does not set its flag again after the flag has been cleared.
- R5: Writing a byte to a flag address clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A flag never falls by any other means.
- R6: When a clear of a flag and a new qualifying edge on its source land in the same clock cycle, the flag ends up set.
- R7: Clearing an enable bit keeps an already-set flag, but stops later edges on that source from setting it.
- R8: The byte at 0x8 returns the index (0 to 23) of the highest-numbered set flag, and 0xFF when no flag is set, including right after reset.
- R9: The byte at 0x9 has bit 2 set when any high-bank flag is set, bit 1 for the mid bank and bit 0 for the low bank; bits 7 to 3 read 0.
- R10: cpu_irq_o[0] is high while any high-bank flag is set, cpu_irq_o[1] while any mid-bank flag is set, and cpu_irq_o[2] while any low-bank flag is set.
- R11: Writes to 0x8 and 0x9 change nothing. Reads of 0x3, 0x7 and 0xA to 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | Asynchronous interrupt source lines, bit k is source k |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cpu_irq_o | output | 3 | Per-bank interrupt lines toward the CPU, bit 0 serviced first |

## Verification
A software clear of a flag and a fresh rising edge on that flag's source can land on the same clock edge. The bench provokes this collision on a flag that is already set. It raises the source and then times a write-one-to-clear so that the write is held across the third clock edge after the rise, which is the edge that registers the new edge. Reading the flag byte afterwards must show the bit still set. A separate clear with no edge in flight must show it drop.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

   localparam int IRQ_ADDR_W = 4;
   localparam int IRQ_DATA_W = 8;

   localparam logic [IRQ_ADDR_W-1:0] A_PRIO = 4'h8;
   localparam logic [IRQ_ADDR_W-1:0] A_SUM  = 4'h9;

   typedef enum logic [1:0] {
      RK_NONE,
      RK_FLAG,
      RK_EN,
      RK_STAT
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [1:0] grp;
      logic       is_sum;
   } reg_sel_t;

   // Address map: 0x0..0x3 flag bytes, 0x4..0x7 enable bytes, 0x8 code, 0x9 summary.
   function automatic reg_sel_t decode(input logic [IRQ_ADDR_W-1:0] a, input int groups);
      reg_sel_t s;
      s.kind   = RK_NONE;
      s.grp    = a[1:0];
      s.is_sum = 1'b0;
      if (a[3:2] == 2'b00 && int'(a[1:0]) < groups) begin
         s.kind = RK_FLAG;
      end else if (a[3:2] == 2'b01 && int'(a[1:0]) < groups) begin
         s.kind = RK_EN;
      end else if (a == A_PRIO) begin
         s.kind = RK_STAT;
      end else if (a == A_SUM) begin
         s.kind   = RK_STAT;
         s.is_sum = 1'b1;
      end
      return s;
   endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_group_slice.sv
module irq_group_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] en_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o,
   output logic         any_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] flag_q;
   logic [W-1:0] rise;
   logic [W-1:0] flag_d;

   // A qualified rising edge wins over a same-cycle clear.
   always_comb begin
      rise   = lvl_i & ~prev_q;
      flag_d = (rise & en_i) | (flag_q & ~clr_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= lvl_i;
         flag_q <= flag_d;
      end
   end

   assign flag_o = flag_q;
   assign any_o  = |flag_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N         = 24,
   parameter int CODE_W    = 8,
   parameter bit HIGH_WINS = 1'b1
) (
   input  logic [N-1:0]      req_i,
   output logic [CODE_W-1:0] code_o
);

   if (N >= (1 << CODE_W) - 1) begin : g_bad_width
      $error("irq_prio_enc: CODE_W too narrow for N plus the idle code");
   end

   if (HIGH_WINS) begin : g_high
      always_comb begin
         code_o = '1;
         for (int i = 0; i < N; i++) begin
            if (req_i[i]) code_o = CODE_W'(i);
         end
      end
   end else begin : g_low
      always_comb begin
         code_o = '1;
         for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = CODE_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
   import irq_grp_pkg::*;
#(
   parameter int GROUPS      = 3,
   parameter int GRP_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NSRC        = GROUPS * GRP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC-1:0]       src_i,
   input  logic [IRQ_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic [IRQ_DATA_W-1:0] bus_wdata,
   output logic [IRQ_DATA_W-1:0] bus_rdata,
   output logic [GROUPS-1:0]     cpu_irq_o
);

   if (GROUPS < 1 || GROUPS > 4) begin : g_bad_groups
      $error("irq_group_ctrl: GROUPS must be 1 to 4");
   end
   if (GRP_W < 1 || GRP_W > IRQ_DATA_W) begin : g_bad_grpw
      $error("irq_group_ctrl: GRP_W must fit the data bus");
   end
   if (NSRC != GROUPS * GRP_W) begin : g_bad_nsrc
      $error("irq_group_ctrl: NSRC must equal GROUPS*GRP_W");
   end
   if (GROUPS > IRQ_DATA_W) begin : g_bad_sum
      $error("irq_group_ctrl: summary byte too narrow");
   end

   reg_sel_t sel;
   assign sel = decode(bus_addr, GROUPS);

   logic [NSRC-1:0]       lvl_sync;
   logic [NSRC-1:0]       flag_all;
   logic [NSRC-1:0]       en_all;
   logic [NSRC-1:0]       clr_all;
   logic [GROUPS-1:0]     grp_any;
   logic [IRQ_DATA_W-1:0] prio_code;

   irq_sync #(
      .W      (NSRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (lvl_sync)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_bank
      logic [GRP_W-1:0] en_q;
      logic             en_hit;
      logic             clr_hit;

      assign en_hit  = bus_wr && sel.kind == RK_EN   && int'(sel.grp) == g;
      assign clr_hit = bus_wr && sel.kind == RK_FLAG && int'(sel.grp) == g;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      en_q <= '0;
         else if (en_hit) en_q <= bus_wdata[GRP_W-1:0];
      end

      assign en_all [g*GRP_W +: GRP_W] = en_q;
      assign clr_all[g*GRP_W +: GRP_W] = clr_hit ? bus_wdata[GRP_W-1:0] : '0;

      irq_group_slice #(
         .W (GRP_W)
      ) u_slice (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl_i  (lvl_sync[g*GRP_W +: GRP_W]),
         .en_i   (en_q),
         .clr_i  (clr_all[g*GRP_W +: GRP_W]),
         .flag_o (flag_all[g*GRP_W +: GRP_W]),
         .any_o  (grp_any[g])
      );

      // The top bank owns the first CPU line.
      assign cpu_irq_o[GROUPS-1-g] = grp_any[g];
   end

   irq_prio_enc #(
      .N         (NSRC),
      .CODE_W    (IRQ_DATA_W),
      .HIGH_WINS (1'b1)
   ) u_prio (
      .req_i  (flag_all),
      .code_o (prio_code)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (sel.kind)
         RK_FLAG: begin
            for (int g = 0; g < GROUPS; g++) begin
               if (int'(sel.grp) == g) bus_rdata[GRP_W-1:0] = flag_all[g*GRP_W +: GRP_W];
            end
         end
         RK_EN: begin
            for (int g = 0; g < GROUPS; g++) begin
               if (int'(sel.grp) == g) bus_rdata[GRP_W-1:0] = en_all[g*GRP_W +: GRP_W];
            end
         end
         RK_STAT: begin
            if (sel.is_sum) bus_rdata[GROUPS-1:0] = grp_any;
            else            bus_rdata = prio_code;
         end
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk
   import irq_grp_pkg::*;
#(
   parameter int GROUPS = 3,
   parameter int GRP_W  = 8,
   parameter int NSRC   = GROUPS * GRP_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NSRC-1:0]       flags,
   input logic [NSRC-1:0]       en,
   input logic [NSRC-1:0]       clr,
   input logic [IRQ_DATA_W-1:0] prio,
   input logic [IRQ_ADDR_W-1:0] addr,
   input logic [IRQ_DATA_W-1:0] rdata,
   input logic [GROUPS-1:0]     irq
);

   // R3: a flag can only rise if its enable was set on the edge that raised it
   assert_en_gates_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~$past(flags)) & ~$past(en)) == '0);

   // R5: a flag only falls under a write-one-to-clear
   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flags) & ~$past(clr) & ~flags) == '0);

   // R8: idle code exactly when nothing is pending
   assert_prio_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) == (prio == '1));

   // R8: a non-idle code names a valid source index
   assert_prio_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prio != '1) |-> (int'(prio) < NSRC));

   // R11: unmapped addresses read as zero
   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (decode(addr, GROUPS).kind == RK_NONE) |-> (rdata == '0));

   for (genvar k = 0; k < GROUPS; k++) begin : g_line
      // R10: line k reflects the bank counted down from the top
      assert_irq_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq[k] == (|flags[(GROUPS-1-k)*GRP_W +: GRP_W]));

      // R9: summary bit g agrees with the CPU line of bank g
      assert_summary_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (addr == A_SUM) |-> (rdata[GROUPS-1-k] == irq[k]));
   end

endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(
   .GROUPS (GROUPS),
   .GRP_W  (GRP_W),
   .NSRC   (NSRC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .flags (flag_all),
   .en    (en_all),
   .clr   (clr_all),
   .prio  (prio_code),
   .addr  (bus_addr),
   .rdata (bus_rdata),
   .irq   (cpu_irq_o)
);

// File: tb/tb_irq_group_ctrl.sv
module tb_irq_group_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] src = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [2:0]  cpu_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_group_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cpu_irq_o (cpu_irq)
   );

   // {source pattern, expected code}
   localparam logic [31:0] VEC_TAB [8] = '{
      {24'h000001, 8'd0},
      {24'h000080, 8'd7},
      {24'h000100, 8'd8},
      {24'h800000, 8'd23},
      {24'h010203, 8'd16},
      {24'h00F000, 8'd15},
      {24'h400001, 8'd22},
      {24'h0A0000, 8'd19}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_w(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_r(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
   endtask

   task automatic clear_all();
      bus_w(4'h0, 8'hFF);
      bus_w(4'h1, 8'hFF);
      bus_w(4'h2, 8'hFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // Reset state
      for (int a = 4; a < 7; a++) begin
         bus_r(4'(a), d);
         chk("R1 enable reset", d, 0);
      end
      bus_r(4'h8, d);
      chk("R8 code after reset", d, 8'hFF);
      bus_r(4'h9, d);
      chk("R9 summary after reset", d, 0);
      chk("R10 lines after reset", cpu_irq, 0);

      // R1: enable read/write
      bus_w(4'h4, 8'h5A);
      bus_w(4'h5, 8'hC3);
      bus_w(4'h6, 8'h81);
      bus_r(4'h4, d); chk("R1 enable low", d, 8'h5A);
      bus_r(4'h5, d); chk("R1 enable mid", d, 8'hC3);
      bus_r(4'h6, d); chk("R1 enable high", d, 8'h81);

      // R3: disabled source does not latch
      bus_w(4'h4, 8'h00);
      bus_w(4'h5, 8'h00);
      bus_w(4'h6, 8'h00);
      @(negedge clk); src = 24'h000020;
      settle();
      @(negedge clk); src = '0;
      settle();
      bus_r(4'h0, d); chk("R3 disabled edge", d, 0);
      bus_r(4'h8, d); chk("R3 code stays idle", d, 8'hFF);

      // Vector table, all sources enabled (R2, R8, R9, R10)
      bus_w(4'h4, 8'hFF);
      bus_w(4'h5, 8'hFF);
      bus_w(4'h6, 8'hFF);
      foreach (VEC_TAB[i]) begin
         logic [23:0] pat;
         logic [7:0]  code;
         pat  = VEC_TAB[i][31:8];
         code = VEC_TAB[i][7:0];
         @(negedge clk); src = pat;
         settle();
         bus_r(4'h0, d); chk("R2 low flags", d, pat[7:0]);
         bus_r(4'h1, d); chk("R2 mid flags", d, pat[15:8]);
         bus_r(4'h2, d); chk("R2 high flags", d, pat[23:16]);
         bus_r(4'h8, d); chk("R8 code", d, code);
         bus_r(4'h9, d); chk("R9 summary", d, {5'b0, |pat[23:16], |pat[15:8], |pat[7:0]});
         chk("R10 lines", cpu_irq, {|pat[7:0], |pat[15:8], |pat[23:16]});
         @(negedge clk); src = '0;
         settle();
         clear_all();
         bus_r(4'h8, d); chk("R8 idle after clear", d, 8'hFF);
      end

      // R2 latency: flag appears after exactly the third edge
      @(negedge clk); src = 24'h000004;
      @(posedge clk); @(posedge clk);
      @(negedge clk); bus_addr = 4'h0; #1;
      chk("R2 not yet after two edges", bus_rdata, 0);
      @(negedge clk); #1;
      chk("R2 set after third edge", bus_rdata, 8'h04);
      @(negedge clk); src = '0;
      settle();

      // R5: W1C selectivity
      @(negedge clk); src = 24'h000003;
      settle();
      @(negedge clk); src = '0;
      settle();
      bus_r(4'h0, d); chk("R5 both set", d, 8'h07);
      bus_w(4'h0, 8'h01);
      bus_r(4'h0, d); chk("R5 clear bit0 only", d, 8'h06);
      bus_w(4'h0, 8'h00);
      bus_r(4'h0, d); chk("R5 zero write keeps", d, 8'h06);

      // R6: clear and new edge in the same cycle on set flag bit 2
      @(negedge clk); src = 24'h000004;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_addr = 4'h0; bus_wdata = 8'h04; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      bus_r(4'h0, d); chk("R6 edge wins over clear", d, 8'h06);

      // R4: level held high does not re-set after clear
      bus_w(4'h0, 8'h04);
      settle();
      bus_r(4'h0, d); chk("R4 held level no reset", d, 8'h02);
      @(negedge clk); src = '0;
      clear_all();

      // R7: disabling keeps the flag, blocks new sets
      @(negedge clk); src = 24'h400000;
      settle();
      @(negedge clk); src = '0;
      bus_w(4'h6, 8'h00);
      bus_r(4'h2, d); chk("R7 flag kept after disable", d, 8'h40);
      bus_w(4'h2, 8'hFF);
      @(negedge clk); src = 24'h400000;
      settle();
      bus_r(4'h2, d); chk("R7 disabled no new set", d, 0);
      chk("R10 high line idle", cpu_irq[0], 0);
      @(negedge clk); src = '0;
      settle();

      // R11: read-only and unmapped addresses
      @(negedge clk); src = 24'h000200;
      settle();
      bus_w(4'h8, 8'h00);
      bus_w(4'h9, 8'hFF);
      bus_r(4'h8, d); chk("R11 code write ignored", d, 8'd9);
      bus_r(4'h9, d); chk("R11 summary write ignored", d, 8'h02);
      bus_r(4'h0, d); chk("R11 low flags untouched", d, 0);
      bus_r(4'h1, d); chk("R11 mid flags untouched", d, 8'h02);
      bus_w(4'h3, 8'hFF);
      bus_w(4'h7, 8'hFF);
      bus_r(4'h3, d); chk("R11 unmapped 0x3", d, 0);
      bus_r(4'h7, d); chk("R11 unmapped 0x7", d, 0);
      bus_r(4'hA, d); chk("R11 unmapped 0xA", d, 0);
      bus_r(4'hF, d); chk("R11 unmapped 0xF", d, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule